// File: doc/BRIEF.md
# Charge Current Limit Supervisor

This block turns a programmed charge-current setting into the current command that is actually issued to the charger. Two sensed quantities adjust it: the battery-side voltage and the die temperature. Both arrive as digital codes, in millivolts and in degrees Celsius. Each quantity drives its own hysteresis state machine. A deeply discharged battery moves the command to a small fixed trickle current. An overheated die removes the command altogether and drops the enable flag.

A sample-valid strobe loads all three inputs together: voltage, temperature and programmed current. Between strobes the inputs are ignored. The command and the enable flag are registered. They change at the clock edge that samples the strobe, so they can be seen one cycle after the strobe is driven. The thermal condition overrides the voltage condition. The undervoltage state is still tracked while the block is in thermal shutdown.

Top module: `chg_limit_sup`

## Requirements
- R1: After reset, chargeEn is 1, currentMa is 0, and neither the trickle state nor the shutdown state is active.
- R2: The inputs take effect only in a cycle where sampleValid is 1. The outputs change at the clock edge that samples sampleValid, and they hold their values in every other cycle whatever the inputs do.
- R3: A sampled battMv strictly below 2500 enters the trickle state. A value of exactly 2500 does not enter it.
- R4: The trickle state is left only when a sampled battMv is strictly above 2700. Samples from 2500 to 2700 inclusive keep the previous trickle state.
- R5: In the trickle state without shutdown, currentMa is the smaller of progMa and 128, and chargeEn is 1.
- R6: dieTempC is a signed two's-complement code. A sampled value strictly above 150 enters shutdown, where currentMa is 0 and chargeEn is 0. A value of exactly 150 does not enter shutdown.
- R7: Shutdown is left only when a sampled dieTempC is strictly below 125. Samples from 125 to 150 inclusive keep the previous shutdown state.
- R8: Shutdown takes priority over trickle. The trickle state keeps following battMv during shutdown, and it takes effect as soon as shutdown ends.
- R9: With neither state active, currentMa equals the sampled progMa and chargeEn is 1. This holds for negative temperatures too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Loads battMv, dieTempC and progMa in this cycle |
| battMv | input | 16 | Battery-side voltage in millivolts, unsigned |
| dieTempC | input | 10 | Die temperature in degrees Celsius, signed |
| progMa | input | 16 | Programmed charge current in milliamps |
| currentMa | output | 16 | Effective charge-current command in milliamps |
| chargeEn | output | 1 | Charging allowed |

## Verification
The assertions assume that sampleValid, battMv, dieTempC and progMa are held at known values from reset onward. The properties based on $past rely on those values being defined in the cycle after each strobe. The properties also judge a strobe from that single sample only: their trickle and normal properties fire only when the temperature is below the exit threshold, so any earlier shutdown is cleared. The bench drives every input on the falling edge and raises sampleValid for exactly one cycle per sample. It changes the inputs freely between strobes, which exercises the ignore rule while keeping every sampled value defined.

// File: rtl/chg_sup_pkg.sv
package chg_sup_pkg;
  typedef struct packed {
    logic load;
    logic trickle;
    logic shutdown;
  } supStrobe_t;
endpackage

// File: rtl/chg_sup_hyst.sv
// Hysteresis state machine with one threshold for entering and one for leaving.
module chg_sup_hyst #(
  parameter int W           = 16,
  parameter int ENTER       = 0,
  parameter int EXIT        = 0,
  parameter bit ENTER_ABOVE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic signed [W-1:0] sample,
  output logic                activeNext,
  output logic                active
);
  localparam logic signed [W-1:0] ENTER_V = ENTER[W-1:0];
  localparam logic signed [W-1:0] EXIT_V  = EXIT[W-1:0];

  logic enterHit;
  logic exitHit;

  generate
    if (ENTER_ABOVE) begin : g_high
      assign enterHit = sample > ENTER_V;
      assign exitHit  = sample < EXIT_V;
    end else begin : g_low
      assign enterHit = sample < ENTER_V;
      assign exitHit  = sample > EXIT_V;
    end
  endgenerate

  always_comb begin
    activeNext = active;
    if (sampleValid) begin
      if (!active && enterHit)     activeNext = 1'b1;
      else if (active && exitHit)  activeNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= activeNext;
  end
endmodule

// File: rtl/chg_sup_ctrl.sv
// Control: two independent hysteresis machines and the strobe bundle.
module chg_sup_ctrl
  import chg_sup_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter int TEMP_W      = 10,
  parameter int UV_ENTER_MV = 2500,
  parameter int UV_EXIT_MV  = 2700,
  parameter int HOT_ENTER_C = 150,
  parameter int HOT_EXIT_C  = 125
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [MV_W-1:0]          battMv,
  input  logic signed [TEMP_W-1:0] dieTempC,
  output supStrobe_t               strobes
);
  localparam int BW = MV_W + 1;

  logic signed [BW-1:0] battSigned;
  logic uvNext, uvState;
  logic hotNext, hotState;

  assign battSigned = {1'b0, battMv};

  chg_sup_hyst #(
    .W(BW), .ENTER(UV_ENTER_MV), .EXIT(UV_EXIT_MV), .ENTER_ABOVE(1'b0)
  ) u_uvHyst (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sample(battSigned),
    .activeNext(uvNext), .active(uvState)
  );

  chg_sup_hyst #(
    .W(TEMP_W), .ENTER(HOT_ENTER_C), .EXIT(HOT_EXIT_C), .ENTER_ABOVE(1'b1)
  ) u_hotHyst (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sample(dieTempC),
    .activeNext(hotNext), .active(hotState)
  );

  always_comb begin
    strobes.load     = sampleValid;
    strobes.trickle  = uvNext;
    strobes.shutdown = hotNext;
  end
endmodule

// File: rtl/chg_sup_dp.sv
// Datapath: selects and registers the current command.
module chg_sup_dp
  import chg_sup_pkg::*;
#(
  parameter int MA_W       = 16,
  parameter int TRICKLE_MA = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  supStrobe_t      strobes,
  input  logic [MA_W-1:0] progMa,
  output logic [MA_W-1:0] currentMa,
  output logic            chargeEn
);
  localparam logic [MA_W-1:0] TRICKLE_V = TRICKLE_MA[MA_W-1:0];

  logic [MA_W-1:0] trickleMa;
  logic [MA_W-1:0] cmdNext;

  assign trickleMa = (progMa < TRICKLE_V) ? progMa : TRICKLE_V;

  always_comb begin
    if (strobes.shutdown)     cmdNext = '0;
    else if (strobes.trickle) cmdNext = trickleMa;
    else                      cmdNext = progMa;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      currentMa <= '0;
      chargeEn  <= 1'b1;
    end else if (strobes.load) begin
      currentMa <= cmdNext;
      chargeEn  <= !strobes.shutdown;
    end
  end
endmodule

// File: rtl/chg_limit_sup.sv
module chg_limit_sup
  import chg_sup_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter int TEMP_W      = 10,
  parameter int MA_W        = 16,
  parameter int UV_ENTER_MV = 2500,
  parameter int UV_EXIT_MV  = 2700,
  parameter int HOT_ENTER_C = 150,
  parameter int HOT_EXIT_C  = 125,
  parameter int TRICKLE_MA  = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [MV_W-1:0]          battMv,
  input  logic signed [TEMP_W-1:0] dieTempC,
  input  logic [MA_W-1:0]          progMa,
  output logic [MA_W-1:0]          currentMa,
  output logic                     chargeEn
);
  supStrobe_t strobes;

  chg_sup_ctrl #(
    .MV_W(MV_W), .TEMP_W(TEMP_W),
    .UV_ENTER_MV(UV_ENTER_MV), .UV_EXIT_MV(UV_EXIT_MV),
    .HOT_ENTER_C(HOT_ENTER_C), .HOT_EXIT_C(HOT_EXIT_C)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .battMv(battMv), .dieTempC(dieTempC), .strobes(strobes)
  );

  chg_sup_dp #(
    .MA_W(MA_W), .TRICKLE_MA(TRICKLE_MA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .progMa(progMa),
    .currentMa(currentMa), .chargeEn(chargeEn)
  );
endmodule

// File: rtl/chg_sup_checker.sv
module chg_sup_checker #(
  parameter int MV_W        = 16,
  parameter int TEMP_W      = 10,
  parameter int MA_W        = 16,
  parameter int UV_ENTER_MV = 2500,
  parameter int UV_EXIT_MV  = 2700,
  parameter int HOT_ENTER_C = 150,
  parameter int HOT_EXIT_C  = 125,
  parameter int TRICKLE_MA  = 128
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic [MV_W-1:0]          battMv,
  input logic signed [TEMP_W-1:0] dieTempC,
  input logic [MA_W-1:0]          progMa,
  input logic [MA_W-1:0]          currentMa,
  input logic                     chargeEn
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (chargeEn && currentMa == '0));

  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(sampleValid)) |-> ($stable(currentMa) && $stable(chargeEn)));

  assert_trickle_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(sampleValid) && $past(battMv) < UV_ENTER_MV
     && $past(dieTempC) < HOT_EXIT_C)
    |-> (chargeEn && currentMa <= TRICKLE_MA && currentMa <= $past(progMa)));

  assert_hot_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(sampleValid) && $past(dieTempC) > HOT_ENTER_C)
    |-> (!chargeEn && currentMa == '0));

  assert_off_means_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !chargeEn |-> currentMa == '0);

  assert_normal_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(sampleValid) && $past(battMv) > UV_EXIT_MV
     && $past(dieTempC) < HOT_EXIT_C)
    |-> (chargeEn && currentMa == $past(progMa)));
endmodule

bind chg_limit_sup chg_sup_checker #(
  .MV_W(MV_W), .TEMP_W(TEMP_W), .MA_W(MA_W),
  .UV_ENTER_MV(UV_ENTER_MV), .UV_EXIT_MV(UV_EXIT_MV),
  .HOT_ENTER_C(HOT_ENTER_C), .HOT_EXIT_C(HOT_EXIT_C),
  .TRICKLE_MA(TRICKLE_MA)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .battMv(battMv),
  .dieTempC(dieTempC), .progMa(progMa), .currentMa(currentMa), .chargeEn(chargeEn)
);

// File: tb/chg_limit_sup_bench.sv
module chg_limit_sup_bench;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [15:0]       battMv = 16'd3000;
  logic signed [9:0] dieTempC = 10'sd25;
  logic [15:0]       progMa = 16'd0;
  logic [15:0]       currentMa;
  logic              chargeEn;

  always #4 clk = ~clk;

  chg_limit_sup u_chg_limit_sup (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .battMv(battMv),
    .dieTempC(dieTempC), .progMa(progMa), .currentMa(currentMa), .chargeEn(chargeEn)
  );

  typedef struct {
    int    ma;
    bit    en;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  vectors = 0;
  int  misses  = 0;
  bit  done    = 1'b0;
  bit  strobeSeen = 1'b0;

  // Reference state taken from the requirements.
  bit  mTrickle = 1'b0;
  bit  mHot     = 1'b0;
  int  lastMa   = 0;
  bit  lastEn   = 1'b1;

  task automatic applySample(input int b, input int t, input int p, input string req);
    expItem_t it;
    if (!mTrickle && b < 2500)     mTrickle = 1'b1;
    else if (mTrickle && b > 2700) mTrickle = 1'b0;
    if (!mHot && t > 150)          mHot = 1'b1;
    else if (mHot && t < 125)      mHot = 1'b0;
    it.en  = !mHot;
    it.ma  = mHot ? 0 : (mTrickle ? ((p < 128) ? p : 128) : p);
    it.req = req;
    lastMa = it.ma;
    lastEn = it.en;
    expQ.push_back(it);
    @(negedge clk);
    battMv      = 16'(b);
    dieTempC    = 10'(t);
    progMa      = 16'(p);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  always @(posedge clk) strobeSeen <= sampleValid;

  // Monitor: one result per strobe, compared in the cycle after the sampling edge.
  always @(negedge clk) begin
    if (strobeSeen) begin
      if (expQ.size() == 0) begin
        misses++;
        $display("FAIL R2 unexpected result: actual=%0d/%0b expected=none", currentMa, chargeEn);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        vectors++;
        if (int'(currentMa) != it.ma || chargeEn != it.en) begin
          misses++;
          $display("FAIL %s: actual ma=%0d en=%0b expected ma=%0d en=%0b",
                   it.req, currentMa, chargeEn, it.ma, it.en);
        end
      end
    end
  end

  task automatic checkHold(input string req);
    vectors++;
    if (int'(currentMa) != lastMa || chargeEn != lastEn) begin
      misses++;
      $display("FAIL %s: actual ma=%0d en=%0b expected ma=%0d en=%0b",
               req, currentMa, chargeEn, lastMa, lastEn);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    vectors++;                                   // R1 reset state
    if (currentMa != 16'd0 || chargeEn != 1'b1) begin
      misses++;
      $display("FAIL R1: actual ma=%0d en=%0b expected ma=0 en=1", currentMa, chargeEn);
    end
    applySample(3000, 25, 1000, "R9 normal pass-through");
    applySample(2500, 25, 1000, "R3 exactly 2500 stays normal");
    applySample(2499, 25, 1000, "R3 below 2500 enters trickle");
    applySample(2600, 25, 1000, "R4 inside band keeps trickle");
    applySample(2700, 25, 1000, "R4 exactly 2700 keeps trickle");
    applySample(2701, 25, 1000, "R4 above 2700 leaves trickle");
    applySample(2600, 25, 1000, "R4 inside band keeps normal");
    applySample(2000, 25, 100,  "R5 trickle uses smaller program");
    applySample(2000, 25, 128,  "R5 trickle equal to cap");
    applySample(2000, 25, 5000, "R5 trickle capped at 128");
    // R2: inputs without strobe must be ignored
    @(negedge clk);
    battMv = 16'd4000; dieTempC = 10'sd200; progMa = 16'd9;
    repeat (4) @(negedge clk);
    checkHold("R2 hold without strobe");
    applySample(3000, 150, 1000, "R6 exactly 150 no shutdown");
    applySample(3000, 151, 1000, "R6 above 150 shuts down");
    applySample(3000, 130, 1000, "R7 inside band keeps shutdown");
    applySample(3000, 125, 1000, "R7 exactly 125 keeps shutdown");
    applySample(3000, 124, 1000, "R7 below 125 resumes");
    applySample(3000, 140, 1000, "R7 inside band keeps running");
    applySample(2000, 200, 1000, "R8 shutdown over trickle");
    applySample(2600, 140, 1000, "R8 still shut down");
    applySample(2600, 100, 1000, "R8 trickle tracked through shutdown");
    applySample(2800, -40, 1000, "R9 negative temperature normal");
    applySample(2800, -40, 0,    "R9 zero program");
    @(negedge clk);
    battMv = 16'd100; dieTempC = -10'sd5; progMa = 16'd777;
    repeat (3) @(negedge clk);
    checkHold("R2 hold after final sample");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      misses++;
      $display("FAIL R2 missing results: actual=%0d pending expected=0", expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule